// File: doc/BRIEF.md
# Dual-Core Thermal Threshold Alert

This block watches one signed temperature byte per core, two cores by default, and compares each byte against a lower and an upper limit that belong to that core alone. A core trips when its reading is at or beyond either limit; reaching a limit is enough. Each trip sets a sticky per-core status flag. When alerting is enabled, any core's trip also pulls a single shared active-low alert line low.

The host finds the source of the alert through the SMBus Alert Response Address read. The SMBus engine pulses a request. If this block holds the line low, it acknowledges on the next cycle, offers its 7-bit address followed by a 0 bit as the response byte, and releases the line. The line goes low again only on a later sample that shows an excursion. The comparison is made only when a reading-valid strobe arrives, so a new limit is used from the next sample onward. The analog conversion sits outside the block.

Top module: `therm_alert_top`

## Requirements
- R1: Readings and limits are signed two's-complement bytes with 1 degree Celsius per LSB, and every comparison is signed (for example, 0x05 is above a lower limit of 0xF6).
- R2: Each core has its own upper and lower limit. A write with `lim_wr_en` high stores `lim_wr_data` into the limit that `lim_wr_sel` selects: bit 0 picks the upper (1) or lower (0) limit, and the remaining bits give the core index. Writes to one core's limits do not change another core's trip result.
- R3: On a clock edge with `sample_valid` high, core c trips high if its reading is >= its upper limit and trips low if its reading is <= its lower limit.
- R4: `alert_n` goes low only after a tripping sample taken while alerting is enabled. Writing the enable to 0 releases `alert_n` on the next cycle and discards the pending alert, so enabling again does not bring it back.
- R5: `status_hi[c]` and `status_lo[c]` are set by a matching trip whether or not alerting is enabled. They stay set through later in-range samples until a `status_clr` pulse. A trip on the same edge as the clear leaves the flag set.
- R6: An `ara_req` pulse while `alert_n` is low gives `ara_ack` high for exactly one cycle on the next cycle, with `ara_byte` equal to {DEV_ADDR, 0} (0x98 for the default address 0x4C), and `alert_n` goes high. An `ara_req` while `alert_n` is high gives no acknowledge. A tripping sample on the same edge as the request keeps the alert low.
- R7: After it is released, `alert_n` stays high until a later sample trips. In-range samples and cycles without a sample leave it high.
- R8: After reset, the upper limits are 127, the lower limits are -128, alerting is disabled, the flags are clear, `alert_n` is 1 and `ara_ack` is 0.
- R9: Flags and alert change only on edges with `sample_valid` high. A limit written on the same edge as a sample takes effect from the following sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Readings are valid this cycle |
| sample_temp | input | NUM_CORES*8 | Per-core signed reading; core c in bits [8c+7:8c] |
| lim_wr_en | input | 1 | Limit write strobe |
| lim_wr_sel | input | SEL_W | {core index, upper/lower} |
| lim_wr_data | input | 8 | Signed limit value |
| en_wr | input | 1 | Alert-enable write strobe |
| en_data | input | 1 | New alert-enable value |
| status_clr | input | 1 | Clear all sticky flags |
| ara_req | input | 1 | Alert Response Address read request |
| alert_n | output | 1 | Shared active-low alert |
| ara_ack | output | 1 | This device answers the ARA read |
| ara_byte | output | 8 | Response byte {DEV_ADDR, 0} |
| status_hi | output | NUM_CORES | Sticky upper-limit excursion flags |
| status_lo | output | NUM_CORES | Sticky lower-limit excursion flags |

## Verification
A corrupted limit register shows up at the status flags on the first sample that falls between the correct limit and the wrong one. For this reason the tests place readings exactly on each limit and one step inside it. A wrong pending-alert bit shows on `alert_n` one cycle after the sample, enable write or ARA request that should have changed it. A flag that is lost or set spuriously is visible on the next cycle, and sticky behaviour is checked by following each trip with an in-range sample.

// File: rtl/therm_alert_pkg.sv
package therm_alert_pkg;

    localparam int TEMP_W = 8;
    localparam int ADDR_W = 7;

    typedef logic signed [TEMP_W-1:0] temp_t;

    typedef struct packed {
        logic high;
        logic low;
    } trip_t;

    typedef enum logic {
        LIM_LOWER = 1'b0,
        LIM_UPPER = 1'b1
    } lim_kind_e;

    localparam temp_t UPPER_AT_RESET = {1'b0, {(TEMP_W-1){1'b1}}};
    localparam temp_t LOWER_AT_RESET = {1'b1, {(TEMP_W-1){1'b0}}};

    function automatic trip_t evaluate(temp_t reading, temp_t upper, temp_t lower);
        trip_t t;
        t.high = (reading >= upper);
        t.low  = (reading <= lower);
        return t;
    endfunction

    function automatic logic [ADDR_W:0] ara_response(logic [ADDR_W-1:0] addr);
        return {addr, 1'b0};
    endfunction

endpackage

// File: rtl/therm_limit_regs.sv
module therm_limit_regs
    import therm_alert_pkg::*;
#(
    parameter int NUM_CORES = 2,
    parameter int SEL_W     = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [SEL_W-1:0]          wr_sel,
    input  temp_t                     wr_data,
    output temp_t [NUM_CORES-1:0]     upper,
    output temp_t [NUM_CORES-1:0]     lower
);
    localparam int IDX_W = SEL_W - 1;

    lim_kind_e kind;
    assign kind = lim_kind_e'(wr_sel[0]);

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic hit;
        assign hit = wr_en && (wr_sel[SEL_W-1:1] == IDX_W'(c));

        always_ff @(posedge clk) begin
            if (rst) begin
                upper[c] <= UPPER_AT_RESET;
                lower[c] <= LOWER_AT_RESET;
            end else if (hit) begin
                if (kind == LIM_UPPER) upper[c] <= wr_data;
                else                   lower[c] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/therm_core_cmp.sv
module therm_core_cmp
    import therm_alert_pkg::*;
(
    input  temp_t reading,
    input  temp_t upper,
    input  temp_t lower,
    output trip_t trip
);
    always_comb trip = evaluate(reading, upper, lower);
endmodule

// File: rtl/therm_status_flags.sv
module therm_status_flags #(
    parameter int NUM_CORES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sample_valid,
    input  logic                 clr,
    input  logic [NUM_CORES-1:0] trip_hi,
    input  logic [NUM_CORES-1:0] trip_lo,
    output logic [NUM_CORES-1:0] hi_q,
    output logic [NUM_CORES-1:0] lo_q
);
    logic [NUM_CORES-1:0] hi_base, lo_base;
    assign hi_base = clr ? '0 : hi_q;
    assign lo_base = clr ? '0 : lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (sample_valid) begin
            hi_q <= hi_base | trip_hi;
            lo_q <= lo_base | trip_lo;
        end else begin
            hi_q <= hi_base;
            lo_q <= lo_base;
        end
    end
endmodule

// File: rtl/therm_alert_ctrl.sv
module therm_alert_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic sample_valid,
    input  logic any_trip,
    input  logic en_wr,
    input  logic en_data,
    input  logic ara_req,
    output logic en_q,
    output logic alert_n,
    output logic ara_ack
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            pend_q  <= 1'b0;
            ara_ack <= 1'b0;
        end else begin
            ara_ack <= ara_req && pend_q;
            if (en_wr) en_q <= en_data;
            if (!en_q || (en_wr && !en_data))
                pend_q <= 1'b0;
            else if (sample_valid && any_trip)
                pend_q <= 1'b1;
            else if (ara_req)
                pend_q <= 1'b0;
        end
    end

    assign alert_n = ~pend_q;
endmodule

// File: rtl/therm_alert_top.sv
module therm_alert_top
    import therm_alert_pkg::*;
#(
    parameter int                NUM_CORES = 2,
    parameter logic [ADDR_W-1:0] DEV_ADDR  = 7'h4C,
    localparam int               IDX_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int               SEL_W     = IDX_W + 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        sample_valid,
    input  logic [NUM_CORES*TEMP_W-1:0] sample_temp,
    input  logic                        lim_wr_en,
    input  logic [SEL_W-1:0]            lim_wr_sel,
    input  logic [TEMP_W-1:0]           lim_wr_data,
    input  logic                        en_wr,
    input  logic                        en_data,
    input  logic                        status_clr,
    input  logic                        ara_req,
    output logic                        alert_n,
    output logic                        ara_ack,
    output logic [ADDR_W:0]             ara_byte,
    output logic [NUM_CORES-1:0]        status_hi,
    output logic [NUM_CORES-1:0]        status_lo
);
    temp_t [NUM_CORES-1:0] upper_lim, lower_lim;
    logic  [NUM_CORES-1:0] trip_hi, trip_lo;
    logic                  alert_en_q;

    therm_limit_regs #(.NUM_CORES(NUM_CORES), .SEL_W(SEL_W)) u_limits (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (lim_wr_en),
        .wr_sel  (lim_wr_sel),
        .wr_data (temp_t'(lim_wr_data)),
        .upper   (upper_lim),
        .lower   (lower_lim)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_cmp
        trip_t t;
        therm_core_cmp u_cmp (
            .reading (temp_t'(sample_temp[c*TEMP_W +: TEMP_W])),
            .upper   (upper_lim[c]),
            .lower   (lower_lim[c]),
            .trip    (t)
        );
        assign trip_hi[c] = t.high;
        assign trip_lo[c] = t.low;
    end

    therm_status_flags #(.NUM_CORES(NUM_CORES)) u_flags (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (sample_valid),
        .clr          (status_clr),
        .trip_hi      (trip_hi),
        .trip_lo      (trip_lo),
        .hi_q         (status_hi),
        .lo_q         (status_lo)
    );

    therm_alert_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (sample_valid),
        .any_trip     (|{trip_hi, trip_lo}),
        .en_wr        (en_wr),
        .en_data      (en_data),
        .ara_req      (ara_req),
        .en_q         (alert_en_q),
        .alert_n      (alert_n),
        .ara_ack      (ara_ack)
    );

    assign ara_byte = ara_response(DEV_ADDR);
endmodule

// File: rtl/therm_alert_chk.sv
module therm_alert_chk #(
    parameter int NUM_CORES = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 sample_valid,
    input logic                 status_clr,
    input logic                 ara_req,
    input logic                 alert_n,
    input logic                 ara_ack,
    input logic                 alert_en_q,
    input logic [NUM_CORES-1:0] status_hi,
    input logic [NUM_CORES-1:0] status_lo
);
    p_alert_needs_en_r4: assert property (@(posedge clk) disable iff (rst)
        !alert_n |-> alert_en_q);

    p_ara_ack_r6: assert property (@(posedge clk) disable iff (rst)
        (ara_req && !alert_n) |=> ara_ack);

    p_ara_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (ara_req && alert_n) |=> !ara_ack);

    p_ara_release_r6: assert property (@(posedge clk) disable iff (rst)
        (ara_req && !alert_n && !sample_valid) |=> alert_n);

    p_no_spont_alert_r7: assert property (@(posedge clk) disable iff (rst)
        (alert_n && !sample_valid) |=> alert_n);

    p_sticky_hi_r5: assert property (@(posedge clk) disable iff (rst)
        !status_clr |=> ((status_hi & $past(status_hi)) == $past(status_hi)));

    p_sticky_lo_r5: assert property (@(posedge clk) disable iff (rst)
        !status_clr |=> ((status_lo & $past(status_lo)) == $past(status_lo)));

    p_no_set_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !sample_valid |=> (((status_hi & ~$past(status_hi)) == '0) &&
                           ((status_lo & ~$past(status_lo)) == '0)));
endmodule

bind therm_alert_top therm_alert_chk #(.NUM_CORES(NUM_CORES)) u_therm_alert_chk (
    .clk          (clk),
    .rst          (rst),
    .sample_valid (sample_valid),
    .status_clr   (status_clr),
    .ara_req      (ara_req),
    .alert_n      (alert_n),
    .ara_ack      (ara_ack),
    .alert_en_q   (alert_en_q),
    .status_hi    (status_hi),
    .status_lo    (status_lo)
);

// File: tb/test_therm_alert_top.sv
module test_therm_alert_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sample_valid = 1'b0;
    logic [15:0] sample_temp = '0;
    logic        lim_wr_en = 1'b0;
    logic [1:0]  lim_wr_sel = '0;
    logic [7:0]  lim_wr_data = '0;
    logic        en_wr = 1'b0;
    logic        en_data = 1'b0;
    logic        status_clr = 1'b0;
    logic        ara_req = 1'b0;
    logic        alert_n, ara_ack;
    logic [7:0]  ara_byte;
    logic [1:0]  status_hi, status_lo;

    int vectors = 0;
    int miscompares = 0;

    always #4 clk = ~clk;

    therm_alert_top i_therm_alert_top (
        .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample_temp(sample_temp),
        .lim_wr_en(lim_wr_en), .lim_wr_sel(lim_wr_sel), .lim_wr_data(lim_wr_data),
        .en_wr(en_wr), .en_data(en_data), .status_clr(status_clr), .ara_req(ara_req),
        .alert_n(alert_n), .ara_ack(ara_ack), .ara_byte(ara_byte),
        .status_hi(status_hi), .status_lo(status_lo)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_sample(input logic [7:0] t0, input logic [7:0] t1);
        @(negedge clk);
        sample_valid = 1'b1;
        sample_temp  = {t1, t0};
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic wr_lim(input int core, input bit upper, input logic [7:0] v);
        @(negedge clk);
        lim_wr_en   = 1'b1;
        lim_wr_sel  = {core[0], upper};
        lim_wr_data = v;
        @(negedge clk);
        lim_wr_en = 1'b0;
    endtask

    task automatic set_en(input bit v);
        @(negedge clk);
        en_wr = 1'b1;
        en_data = v;
        @(negedge clk);
        en_wr = 1'b0;
    endtask

    task automatic clr_flags();
        @(negedge clk);
        status_clr = 1'b1;
        @(negedge clk);
        status_clr = 1'b0;
    endtask

    task automatic do_ara();
        @(negedge clk);
        ara_req = 1'b1;
        @(negedge clk);
        ara_req = 1'b0;
    endtask

    task automatic test_reset();
        chk("R8 alert_n after reset", alert_n, 1);
        chk("R8 ara_ack after reset", ara_ack, 0);
        chk("R8 status_hi after reset", status_hi, 0);
        chk("R8 status_lo after reset", status_lo, 0);
        do_sample(8'd126, 8'h81);
        chk("R8 one inside reset limits hi", status_hi, 0);
        chk("R8 one inside reset limits lo", status_lo, 0);
        do_sample(8'h7F, 8'h80);
        chk("R8 reading 127 reaches reset upper", status_hi, 2'b01);
        chk("R8 reading -128 reaches reset lower", status_lo, 2'b10);
        chk("R8 alert disabled at reset", alert_n, 1);
        clr_flags();
    endtask

    task automatic test_equality();
        wr_lim(0, 1'b1, 8'd80);
        do_sample(8'd80, 8'd0);
        chk("R3 equal to upper trips", status_hi, 2'b01);
        chk("R3 no low trip", status_lo, 0);
        clr_flags();
        do_sample(8'd79, 8'd0);
        chk("R3 below upper no trip", status_hi, 0);
        wr_lim(0, 1'b0, 8'd20);
        do_sample(8'd20, 8'd0);
        chk("R3 equal to lower trips", status_lo, 2'b01);
        clr_flags();
        do_sample(8'd21, 8'd0);
        chk("R3 above lower no trip", status_lo, 0);
    endtask

    task automatic test_signed();
        wr_lim(1, 1'b0, 8'hF6);
        do_sample(8'd50, 8'h05);
        chk("R1 +5 above -10 lower", status_lo, 0);
        do_sample(8'd50, 8'hF6);
        chk("R1 -10 at -10 lower", status_lo, 2'b10);
        clr_flags();
        do_sample(8'd50, 8'hF7);
        chk("R1 -9 above -10 lower", status_lo, 0);
        do_sample(8'd50, 8'h90);
        chk("R1 -112 not above 127 upper", status_hi, 0);
        clr_flags();
    endtask

    task automatic test_independent();
        wr_lim(0, 1'b1, 8'd50);
        wr_lim(1, 1'b1, 8'd100);
        do_sample(8'd60, 8'd60);
        chk("R2 only core0 over its limit", status_hi, 2'b01);
        chk("R2 no low trips", status_lo, 0);
        clr_flags();
        do_sample(8'd40, 8'd100);
        chk("R2 only core1 at its limit", status_hi, 2'b10);
        clr_flags();
    endtask

    task automatic test_enable();
        do_sample(8'd60, 8'd0);
        chk("R4 disabled trip no alert", alert_n, 1);
        chk("R5 flag set while disabled", status_hi, 2'b01);
        clr_flags();
        set_en(1'b1);
        do_sample(8'd30, 8'd0);
        chk("R4 in-range no alert", alert_n, 1);
        do_sample(8'd60, 8'd0);
        chk("R4 enabled trip alerts", alert_n, 0);
        set_en(1'b0);
        chk("R4 disable releases", alert_n, 1);
        set_en(1'b1);
        chk("R4 re-enable keeps released", alert_n, 1);
        clr_flags();
    endtask

    task automatic test_sticky();
        do_sample(8'd60, 8'd0);
        chk("R5 trip sets flag", status_hi, 2'b01);
        do_sample(8'd30, 8'd0);
        chk("R5 flag sticky after in-range", status_hi, 2'b01);
        clr_flags();
        chk("R5 clear empties flags", status_hi, 0);
        @(negedge clk);
        sample_valid = 1'b1;
        sample_temp  = {8'd0, 8'd60};
        status_clr   = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
        status_clr   = 1'b0;
        chk("R5 set wins over clear", status_hi, 2'b01);
        clr_flags();
    endtask

    task automatic test_ara();
        chk("R6 alert held before ARA", alert_n, 0);
        do_ara();
        chk("R6 ack after request", ara_ack, 1);
        chk("R6 response byte", ara_byte, 8'h98);
        chk("R6 alert released", alert_n, 1);
        @(negedge clk);
        chk("R6 ack one cycle only", ara_ack, 0);
        do_sample(8'd30, 8'd0);
        chk("R7 in-range keeps released", alert_n, 1);
        do_ara();
        chk("R6 no ack when not alerting", ara_ack, 0);
        do_sample(8'd60, 8'd0);
        chk("R7 new excursion reasserts", alert_n, 0);
        do_ara();
        chk("R6 second release", alert_n, 1);
        clr_flags();
    endtask

    task automatic test_timing();
        wr_lim(0, 1'b1, 8'd90);
        do_sample(8'd95, 8'd0);
        chk("R9 trip at new limit", status_hi, 2'b01);
        do_ara();
        clr_flags();
        wr_lim(0, 1'b1, 8'd100);
        chk("R9 write alone no flag", status_hi, 0);
        chk("R9 write alone no alert", alert_n, 1);
        do_sample(8'd95, 8'd0);
        chk("R9 95 under 100", status_hi, 0);
        @(negedge clk);
        lim_wr_en   = 1'b1;
        lim_wr_sel  = 2'b01;
        lim_wr_data = 8'd90;
        sample_valid = 1'b1;
        sample_temp  = {8'd0, 8'd95};
        @(negedge clk);
        lim_wr_en    = 1'b0;
        sample_valid = 1'b0;
        chk("R9 same-edge write uses old limit", status_hi, 0);
        do_sample(8'd95, 8'd0);
        chk("R9 next sample uses new limit", status_hi, 2'b01);
        chk("R9 alert on next sample", alert_n, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_equality();
        test_signed();
        test_independent();
        test_enable();
        test_sticky();
        test_ara();
        test_timing();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule